// File: doc/BRIEF.md
# Bit-Matrix Least-Recently-Used Frame Tracker

This block keeps the exact recency order of a small set of page frames. It uses a square bit matrix with one row and one column per frame. When the block sees a touch of frame k, it sets row k to ones in the same clock edge and clears column k. So row k ends as the most recent entry, and every other row loses its claim that it is newer than k. Read each row as an unsigned number with column j at bit j. The values then fall strictly with age, and the smallest row belongs to the frame that was used least recently.

A replacement controller drives a one-cycle access strobe with a frame index on every touch. It reads the victim index combinationally at any time. The full matrix is also exposed as a flat vector so that tests can observe it. The frame count is a parameter from 2 to 8, with a default of 4. The index port always has three bits, and any value at or above the frame count is dropped.

Top module: `lru_mtx_tracker`

## Requirements
- R1: After reset, every matrix bit is zero and the victim index reads 0.
- R2: On the edge after an accepted access to frame k, row k holds ones in every column except column k, which is zero.
- R3: An accepted access to frame k clears bit k of every other row in the same edge and leaves their other bits unchanged.
- R4: The victim index is, combinationally, the row whose value is smallest as an unsigned number with column j at bit j.
- R5: When several rows share the smallest value, the lowest row index is reported.
- R6: A cycle with the strobe low leaves the matrix and the victim index unchanged, whatever the index port carries.
- R7: A strobe whose index (a 3-bit unsigned value) is at or above the frame count leaves the matrix unchanged.
- R8: With 4 frames, the touch order 0,1,2,3,2,1,0,3,2,3 gives the victims 1,2,3,0,0,0,3,2,1,1 after each touch in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | Access strobe, one per touched frame |
| acc_idx | input | 3 | Index of the touched frame |
| lru_idx | output | 3 | Index of the least recently used frame |
| rows_flat | output | N*N | Matrix for observation; row i is at bits [i*N +: N] |

## Verification
The bench keeps a timestamp for the last touch of each frame. From those timestamps it derives both the expected matrix and the expected victim, so it never relies on the matrix rule itself. A design that lets the row set win over the column clear would leave a one on the diagonal, and a row check would show it. A design that picks the last index on a tie would name frame 3 instead of frame 0 right after reset. Strobes with indices 4 to 7, and an index that moves while the strobe is low, test whether the matrix is corrupted when a bad index wraps or when the strobe decode is missing. Repeated touches of the same frame and strobes in back-to-back cycles test whether each edge updates the matrix correctly on its own.

// File: rtl/lru_mtx_pkg.sv
package lru_mtx_pkg;
  localparam int LRU_MAX_FRAMES = 8;
  localparam int LRU_IDX_W      = 3;

  typedef logic [LRU_IDX_W-1:0]      frame_idx_t;
  typedef logic [LRU_MAX_FRAMES-1:0] wide_row_t;

  // One-hot mask for column k at the widest frame count.
  function automatic wide_row_t col_mask(input frame_idx_t k);
    return wide_row_t'(1) << k;
  endfunction

  // Next value of row `self` after a touch of frame k (set row, clear column).
  function automatic wide_row_t row_update(input wide_row_t  old_row,
                                           input frame_idx_t self,
                                           input frame_idx_t k,
                                           input logic       hit);
    if (!hit)
      return old_row;
    if (k == self)
      return ~col_mask(k);
    return old_row & ~col_mask(k);
  endfunction
endpackage

// File: rtl/lru_mtx_row.sv
module lru_mtx_row
  import lru_mtx_pkg::*;
#(
  parameter int N   = 4,
  parameter int ROW = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  frame_idx_t idx,
  output logic [N-1:0] row_q
);
  localparam frame_idx_t SELF = frame_idx_t'(ROW);

  wide_row_t      nxt_wide;
  logic [N-1:0]   kmask;
  logic           own_touch;

  assign nxt_wide  = row_update(wide_row_t'(row_q), SELF, idx, hit);
  assign kmask     = N'(1) << idx;
  assign own_touch = hit && (idx == SELF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '0;
    else
      row_q <= nxt_wide[N-1:0];
  end

  AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    row_q[ROW] == 1'b0); // R2

  AST_ROW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    own_touch |=> (row_q == ~N'(1 << ROW))); // R2

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !own_touch) |=> ((row_q & $past(kmask)) == '0)); // R3

  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !own_touch) |=> ((row_q & ~$past(kmask)) == ($past(row_q) & ~$past(kmask)))); // R3
endmodule

// File: rtl/lru_mtx_pick.sv
module lru_mtx_pick
  import lru_mtx_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*N-1:0] rows_flat,
  output frame_idx_t     lru_idx
);
  logic [N-1:0] best_val;

  // Linear scan with strict less-than: the lowest index wins on equal rows.
  always_comb begin
    lru_idx  = '0;
    best_val = rows_flat[0 +: N];
    for (int i = 1; i < N; i++) begin
      if (rows_flat[i*N +: N] < best_val) begin
        best_val = rows_flat[i*N +: N];
        lru_idx  = frame_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/lru_mtx_tracker.sv
module lru_mtx_tracker
  import lru_mtx_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_vld,
  input  logic [2:0]     acc_idx,
  output logic [2:0]     lru_idx,
  output logic [N*N-1:0] rows_flat
);
  localparam logic [3:0] N_LIM = 4'(N);

  logic hit_ev;
  logic oor_ev;

  assign hit_ev = acc_vld && ({1'b0, acc_idx} < N_LIM);
  assign oor_ev = acc_vld && !hit_ev;

  for (genvar r = 0; r < N; r++) begin : g_row
    lru_mtx_row #(.N(N), .ROW(r)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit_ev),
      .idx   (acc_idx),
      .row_q (rows_flat[r*N +: N])
    );
  end

  lru_mtx_pick #(.N(N)) u_pick (
    .rows_flat (rows_flat),
    .lru_idx   (lru_idx)
  );

  AST_LRU_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, lru_idx} < N_LIM); // R4

  AST_VICTIM_NOT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (lru_idx != $past(acc_idx))); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(rows_flat)); // R6

  AST_OOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    oor_ev |=> $stable(rows_flat)); // R7
endmodule

// File: tb/lru_mtx_tracker_test.sv
module lru_mtx_tracker_test;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           acc_vld = 1'b0;
  logic [2:0]     acc_idx = '0;
  logic [2:0]     lru_idx;
  logic [N*N-1:0] rows_flat;

  int total = 0;
  int bad   = 0;
  int stamp [N];
  int now   = 0;

  always #2 clk = ~clk;

  lru_mtx_tracker #(.N(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .acc_idx   (acc_idx),
    .lru_idx   (lru_idx),
    .rows_flat (rows_flat)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_row(input int i);
    int v = 0;
    for (int j = 0; j < N; j++)
      if (stamp[i] > stamp[j]) v |= (1 << j);
    return v;
  endfunction

  function automatic int exp_lru();
    int b = 0;
    for (int i = 1; i < N; i++)
      if (stamp[i] < stamp[b]) b = i;
    return b;
  endfunction

  task automatic chk_state(input string req);
    for (int i = 0; i < N; i++)
      chk(req, int'(rows_flat[i*N +: N]), exp_row(i));
    chk(req, int'(lru_idx), exp_lru());
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) stamp[i] = 0;
    now = 0;
  endtask

  task automatic touch(input int k);
    @(negedge clk);
    acc_vld = 1'b1;
    acc_idx = 3'(k);
    @(posedge clk);
    #1;
    acc_vld = 1'b0;
    if (k < N) begin
      now++;
      stamp[k] = now;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    #3;
    chk("R1 rows", int'(rows_flat), 0);
    chk("R1 lru", int'(lru_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_ties();
    t_reset();
    touch(2);
    chk("R5 tie after one touch", int'(lru_idx), 0);
    chk_state("R2 R3 first touch");
    touch(0);
    chk("R5 tie two touched", int'(lru_idx), 1);
    chk_state("R3 second touch");
  endtask

  task automatic t_sequence();
    int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
    int vic [10] = '{1, 2, 3, 0, 0, 0, 3, 2, 1, 1};
    t_reset();
    for (int s = 0; s < 10; s++) begin
      touch(seq[s]);
      chk("R8 victim", int'(lru_idx), vic[s]);
      chk_state("R2 R3 R4 sequence");
    end
  endtask

  task automatic t_back_to_back();
    t_reset();
    @(negedge clk);
    acc_vld = 1'b1;
    for (int k = N - 1; k >= 0; k--) begin
      acc_idx = 3'(k);
      @(negedge clk);
      now++;
      stamp[k] = now;
    end
    acc_vld = 1'b0;
    chk_state("R4 back to back");
    chk("R4 oldest is 3", int'(lru_idx), 3);
    touch(1);
    touch(1);
    chk_state("R2 repeated touch");
  endtask

  task automatic t_idle();
    int snap;
    snap = int'(rows_flat);
    @(negedge clk);
    acc_vld = 1'b0;
    for (int k = 0; k < 8; k++) begin
      acc_idx = 3'(k);
      @(negedge clk);
    end
    chk("R6 rows held", int'(rows_flat), snap);
    chk_state("R6 idle");
  endtask

  task automatic t_out_of_range();
    int snap;
    snap = int'(rows_flat);
    for (int k = N; k < 8; k++) touch(k);
    chk("R7 rows held", int'(rows_flat), snap);
    chk_state("R7 out of range");
    touch(0);
    chk_state("R7 legal touch after");
  endtask

  initial begin
    model_clear();
    #3;
    chk("R1 rows at start", int'(rows_flat), 0);
    chk("R1 lru at start", int'(lru_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_ties();
    t_sequence();
    t_back_to_back();
    t_idle();
    t_out_of_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule